// File: doc/BRIEF.md
# UART FIFO DMA Request Controller

This block connects the 32-entry transmit and receive FIFOs of a serial port to a DMA engine. It drives two request lines: a receive request, asking the DMA engine to empty the receive FIFO, and a transmit request, asking it to refill the transmit FIFO. Each request switches on when the FIFO occupancy crosses a programmable trigger level. Once on, it stays on until the FIFO is completely empty (receive) or completely full (transmit). This gives each request hysteresis instead of a plain comparison.

A single 32-bit configuration word holds the two trigger levels and the two channel enables. Software reads it back through the same register port. The block also decodes accesses to the shared byte-wide data register. A read of it pops the receive FIFO and a write of it pushes the transmit FIFO. Each DMA acknowledge that arrives while its request is high produces the same kind of strobe.

Top module: `uart_dma_req_ctrl`

## Requirements
- R1: After reset, the configuration word reads 0, both request outputs are low, and both FIFO strobes are low while no access or acknowledge is applied.
- R2: A configuration write takes effect at the next clock edge. The receive trigger level is bits 21:16, the transmit trigger level is bits 13:8, the receive enable is bit 1 and the transmit enable is bit 0. All other bits ignore writes and read as 0, so writing all ones reads back 0x003F3F03.
- R3: With the receive enable set, the receive request rises one cycle after a cycle in which the receive occupancy is strictly greater than the receive trigger level. An occupancy equal to the trigger level does not start it.
- R4: Once started, the receive request stays high while the occupancy is nonzero, even below the trigger level. It falls one cycle after a cycle with occupancy 0, and it does not restart until the start condition of R3 holds again.
- R5: With the transmit enable set, the transmit request rises one cycle after a cycle in which the transmit occupancy is strictly less than the transmit trigger level. An occupancy equal to the trigger level does not start it.
- R6: Once started, the transmit request stays high until one cycle after a cycle with the occupancy at 32 (full).
- R7: Clearing a channel enable drops that request in the same cycle the new configuration takes effect, and clears its held state. After re-enabling, the request stays low until the start condition holds again.
- R8: A trigger level above 32 is stored and read back unchanged, but acts as 32. With a receive level of 40, an occupancy of 32 does not start the receive request. With a transmit level of 40, an occupancy of 31 starts the transmit request.
- R9: A data-register read raises the receive pop strobe, and a data-register write raises the transmit push strobe, in the same cycle.
- R10: A DMA acknowledge raises one pop (receive) or push (transmit) strobe in its own cycle while the matching request is high. An acknowledge while the request is low produces no strobe.
- R11: With a transmit trigger level of 0, the transmit request never starts, even with an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| data_rd | input | 1 | Read of the shared data register |
| data_wr | input | 1 | Write of the shared data register |
| rx_level | input | 6 | Receive FIFO occupancy (0 to 32) |
| tx_level | input | 6 | Transmit FIFO occupancy (0 to 32) |
| rx_dma_ack | input | 1 | DMA acknowledge for the receive request |
| tx_dma_ack | input | 1 | DMA acknowledge for the transmit request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| tx_push | output | 1 | Push strobe to the transmit FIFO |

## Verification
The hardest state to reach from the ports is a channel whose held request was cleared by a disable. The receive occupancy must then sit between zero and the trigger level, so a restart is not allowed but a surviving hold would keep the request high. The stimulus first starts the request with a high occupancy. It then disables the channel and, on the very next cycle, re-enables it while the occupancy is lowered below the trigger. Only a correctly cleared held state keeps the request low. Comparisons exactly at the trigger levels, and trigger levels of 0 and above 32, cover the remaining edges of the hysteresis.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
   localparam int unsigned THR_W  = 6;
   localparam int unsigned RX_LSB = 16;
   localparam int unsigned TX_LSB = 8;
   localparam int unsigned RXEN_B = 1;
   localparam int unsigned TXEN_B = 0;

   typedef struct packed {
      logic [THR_W-1:0] rx_thr;
      logic [THR_W-1:0] tx_thr;
      logic             rx_en;
      logic             tx_en;
   } dma_cfg_t;
endpackage

// File: rtl/uart_dma_cfg.sv
module uart_dma_cfg
   import uart_dma_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] rdata_o,
   output dma_cfg_t          cfg_o
);
   initial begin
      assert (WORD_W >= RX_LSB + THR_W)
         else $error("configuration word too narrow");
   end

   dma_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we_i) begin
         cfg_q.rx_thr <= wdata_i[RX_LSB +: THR_W];
         cfg_q.tx_thr <= wdata_i[TX_LSB +: THR_W];
         cfg_q.rx_en  <= wdata_i[RXEN_B];
         cfg_q.tx_en  <= wdata_i[TXEN_B];
      end
   end

   always_comb begin
      rdata_o                   = '0;
      rdata_o[RX_LSB +: THR_W]  = cfg_q.rx_thr;
      rdata_o[TX_LSB +: THR_W]  = cfg_q.tx_thr;
      rdata_o[RXEN_B]           = cfg_q.rx_en;
      rdata_o[TXEN_B]           = cfg_q.tx_en;
   end

   assign cfg_o = cfg_q;
endmodule

// File: rtl/uart_dma_chan.sv
module uart_dma_chan #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned LVL_W = 6,
   parameter int unsigned THR_W = 6,
   parameter bit          IS_RX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [THR_W-1:0] thr_i,
   input  logic [LVL_W-1:0] level_i,
   input  logic             ack_i,
   input  logic             cpu_stb_i,
   output logic             req_o,
   output logic             stb_o
);
   localparam int unsigned CW = ((THR_W > LVL_W) ? THR_W : LVL_W) + 1;

   initial begin
      assert (DEPTH >= 2) else $error("DEPTH too small");
      assert (DEPTH < (2 ** LVL_W)) else $error("LVL_W too narrow");
   end

   logic [CW-1:0] thr_eff;
   logic [CW-1:0] lvl_x;
   logic          start;
   logic          stop;
   logic          active_q;
   logic          active_d;

   always_comb begin
      lvl_x   = CW'(level_i);
      thr_eff = (CW'(thr_i) > CW'(DEPTH)) ? CW'(DEPTH) : CW'(thr_i);
   end

   generate
      if (IS_RX) begin : g_rx
         always_comb begin
            start = lvl_x > thr_eff;
            stop  = lvl_x == '0;
         end
      end else begin : g_tx
         always_comb begin
            start = lvl_x < thr_eff;
            stop  = lvl_x == CW'(DEPTH);
         end
      end
   endgenerate

   always_comb active_d = en_i && (active_q ? !stop : start);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= active_d;
   end

   assign req_o = active_q && en_i;
   assign stb_o = cpu_stb_i || (ack_i && req_o);

   // Re-enable after a disable cycle must not revive a held request
   p_reenable_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(en_i) && en_i) |-> !req_o);

   generate
      if (IS_RX) begin : g_rx_chk
         p_rx_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_o) |-> ($past(lvl_x) > $past(thr_eff)));
         p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o && level_i != '0) |=> (req_o || !en_i));
      end else begin : g_tx_chk
         p_tx_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_o) |-> ($past(lvl_x) < $past(thr_eff)));
         p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o && lvl_x != CW'(DEPTH)) |=> (req_o || !en_i));
      end
   endgenerate
endmodule

// File: rtl/uart_dma_req_ctrl.sv
module uart_dma_req_ctrl
   import uart_dma_pkg::*;
#(
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WORD_W-1:0] cfg_wdata,
   output logic [WORD_W-1:0] cfg_rdata,
   input  logic              data_rd,
   input  logic              data_wr,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [LVL_W-1:0]  tx_level,
   input  logic              rx_dma_ack,
   input  logic              tx_dma_ack,
   output logic              rx_dma_req,
   output logic              tx_dma_req,
   output logic              rx_pop,
   output logic              tx_push
);
   initial begin
      assert (DEPTH < (2 ** THR_W)) else $error("DEPTH exceeds trigger field");
   end

   dma_cfg_t cfg;

   uart_dma_cfg #(.WORD_W(WORD_W)) i_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we),
      .wdata_i (cfg_wdata),
      .rdata_o (cfg_rdata),
      .cfg_o   (cfg)
   );

   uart_dma_chan #(.DEPTH(DEPTH), .LVL_W(LVL_W), .THR_W(THR_W), .IS_RX(1'b1)) i_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (cfg.rx_en),
      .thr_i     (cfg.rx_thr),
      .level_i   (rx_level),
      .ack_i     (rx_dma_ack),
      .cpu_stb_i (data_rd),
      .req_o     (rx_dma_req),
      .stb_o     (rx_pop)
   );

   uart_dma_chan #(.DEPTH(DEPTH), .LVL_W(LVL_W), .THR_W(THR_W), .IS_RX(1'b0)) i_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (cfg.tx_en),
      .thr_i     (cfg.tx_thr),
      .level_i   (tx_level),
      .ack_i     (tx_dma_ack),
      .cpu_stb_i (data_wr),
      .req_o     (tx_dma_req),
      .stb_o     (tx_push)
   );

   // An acknowledge with its request high always yields a strobe
   p_ack_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_dma_ack && rx_dma_req) |-> rx_pop) and ((tx_dma_ack && tx_dma_req) |-> tx_push));
endmodule

// File: tb/test_uart_dma_req_ctrl.sv
`timescale 1ns/1ps
module test_uart_dma_req_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        data_rd = 1'b0, data_wr = 1'b0;
   logic [5:0]  rx_level = 6'd0, tx_level = 6'd32;
   logic        rx_dma_ack = 1'b0, tx_dma_ack = 1'b0;
   logic        rx_dma_req, tx_dma_req, rx_pop, tx_push;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   typedef struct {
      logic       rxreq, txreq, pop, push;
      logic [31:0] rdata;
      string      tag;
   } exp_t;
   exp_t q[$];

   always #2.5 clk = ~clk;

   uart_dma_req_ctrl i_uart_dma_req_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .data_rd(data_rd), .data_wr(data_wr),
      .rx_level(rx_level), .tx_level(tx_level), .rx_dma_ack(rx_dma_ack),
      .tx_dma_ack(tx_dma_ack), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
      .rx_pop(rx_pop), .tx_push(tx_push)
   );

   // Monitor: compares each cycle's outputs at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         tests++;
         if (rx_dma_req !== e.rxreq || tx_dma_req !== e.txreq || rx_pop !== e.pop ||
             tx_push !== e.push || cfg_rdata !== e.rdata) begin
            fails++;
            $display("FAIL %s: got rxreq=%b txreq=%b pop=%b push=%b rdata=%h, expected rxreq=%b txreq=%b pop=%b push=%b rdata=%h",
                     e.tag, rx_dma_req, tx_dma_req, rx_pop, tx_push, cfg_rdata,
                     e.rxreq, e.txreq, e.pop, e.push, e.rdata);
         end
      end
   end

   // Driver: applies one cycle of stimulus and queues what that cycle must show
   task automatic step(input logic we, input logic [31:0] wd, input logic [5:0] rxl,
                       input logic [5:0] txl, input logic rd, input logic wr,
                       input logic rack, input logic tack,
                       input logic erx, input logic etx, input logic epop,
                       input logic epush, input logic [31:0] erd, input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      cfg_we = we; cfg_wdata = wd; rx_level = rxl; tx_level = txl;
      data_rd = rd; data_wr = wr; rx_dma_ack = rack; tx_dma_ack = tack;
      e.rxreq = erx; e.txreq = etx; e.pop = epop; e.push = epush;
      e.rdata = erd; e.tag = tag;
      q.push_back(e);
   endtask

   initial begin
      #5000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #12 rst_n = 1'b1;
      //    we wdata         rxl txl rd wr ra ta  erx etx pop psh rdata
      step(0, 32'h0,         0, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h0, "R1 reset state");
      step(1, 32'hFFFFFFFF,  0, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h0, "R1 before write lands");
      step(0, 32'h0,         0, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h003F3F03, "R2 reserved bits read zero");
      step(1, 32'h00040002,  0, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h003F3F03, "R2 full tx idle");
      step(0, 32'h0,         4, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00040002, "R2 field readback");
      step(0, 32'h0,         5, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00040002, "R3 equal level no start");
      step(0, 32'h0,         5, 32, 0, 0, 0, 0,  1, 0, 0, 0, 32'h00040002, "R3 rx start");
      step(0, 32'h0,         1, 32, 1, 0, 0, 0,  1, 0, 1, 0, 32'h00040002, "R9 data read pops");
      step(0, 32'h0,         1, 32, 0, 0, 1, 0,  1, 0, 1, 0, 32'h00040002, "R10 rx ack pops, R4 hold");
      step(0, 32'h0,         0, 32, 0, 0, 0, 0,  1, 0, 0, 0, 32'h00040002, "R4 hold at level 1");
      step(0, 32'h0,         0, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00040002, "R4 drop at empty");
      step(0, 32'h0,         0, 32, 0, 0, 1, 0,  0, 0, 0, 0, 32'h00040002, "R10 ack without req ignored");
      step(0, 32'h0,         3, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00040002, "R4 no restart");
      step(0, 32'h0,        10, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00040002, "R4 below trigger stays low");
      step(1, 32'h00040000, 10, 32, 0, 0, 0, 0,  1, 0, 0, 0, 32'h00040002, "R3 restart");
      step(1, 32'h00040002,  3, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00040000, "R7 disable drops req");
      step(0, 32'h0,         3, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00040002, "R7 re-enable stays low");
      step(0, 32'h0,         3, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00040002, "R7 held state cleared");
      step(1, 32'h00280002,  0, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00040002, "R8 write rx 40");
      step(0, 32'h0,        32, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00280002, "R8 rx 40 stored");
      step(0, 32'h0,        32, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00280002, "R8 rx full no start");
      step(1, 32'h00002801,  0, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00280002, "R8 rx still low");
      step(0, 32'h0,         0, 31, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00002801, "R8 tx 40 stored");
      step(0, 32'h0,         0, 31, 0, 1, 0, 0,  0, 1, 0, 1, 32'h00002801, "R8 tx 40 acts as 32, R9 push");
      step(0, 32'h0,         0, 31, 0, 0, 0, 1,  0, 1, 0, 1, 32'h00002801, "R10 tx ack pushes");
      step(0, 32'h0,         0, 32, 0, 0, 0, 0,  0, 1, 0, 0, 32'h00002801, "R6 hold until full");
      step(0, 32'h0,         0, 32, 0, 0, 0, 1,  0, 0, 0, 0, 32'h00002801, "R6 drop at full, R10 idle ack");
      step(1, 32'h00000801,  0, 32, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00002801, "R5 write tx 8");
      step(0, 32'h0,         0,  8, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00000801, "R5 readback");
      step(0, 32'h0,         0,  7, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00000801, "R5 equal level no start");
      step(0, 32'h0,         0, 20, 0, 0, 0, 0,  0, 1, 0, 0, 32'h00000801, "R5 tx start");
      step(0, 32'h0,         0, 20, 0, 0, 0, 0,  0, 1, 0, 0, 32'h00000801, "R6 hold above trigger");
      step(1, 32'h00000001, 0, 20, 0, 0, 0, 0,  0, 1, 0, 0, 32'h00000801, "R6 hold");
      step(0, 32'h0,         0,  0, 0, 0, 0, 0,  0, 1, 0, 0, 32'h00000001, "R6 hold through cfg change");
      step(0, 32'h0,         0, 32, 0, 0, 0, 0,  0, 1, 0, 0, 32'h00000001, "R6 hold at empty");
      step(0, 32'h0,         0,  0, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00000001, "R6 drop at full");
      step(0, 32'h0,         0,  0, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00000001, "R11 tx level 0 never starts");
      step(0, 32'h0,         0,  0, 0, 0, 0, 0,  0, 0, 0, 0, 32'h00000001, "R11 empty still idle");
      @(posedge clk);
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule